// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution Unit

This unit computes the AES byte substitution or its inverse on one byte per clock, chosen per byte by a mode input. It holds no 256-entry table. The byte is carried by a linear change of basis into a tower field built as GF(((2^2)^2)^2). It is inverted there using only GF(2^4) and GF(2^2) arithmetic, and then carried back. The forward affine step follows the return mapping. The inverse affine step comes before the entry mapping. Both directions share one inversion datapath.

The path is cut into four register stages. The first stage holds the entry mapping. The second holds the GF(2^4) norm of the tower element. The third holds the inverse of that norm. The fourth holds the recombined and remapped result. A byte presented with `in_valid` high appears with `out_valid` four clocks later. The mode bit travels down the pipe beside its byte, so neighbouring bytes may use different directions. The tower field uses x^2+x+1 over GF(2), x^2+x+{10} over GF(2^2) and x^2+x+{1100} over GF(2^4). The change-of-basis matrices are derived from these polynomials when the design is elaborated.

Top module: `aes_cf_sbox`

## Requirements
- R1: With `in_mode` = 0 (forward), `out_data` equals the AES S-box value of the input byte, for all 256 inputs.
- R2: With `in_mode` = 1 (inverse), `out_data` equals the AES inverse S-box value of the input byte, for all 256 inputs.
- R3: Zero inverts to zero, so forward 0x00 gives 0x63 and inverse 0x63 gives 0x00.
- R4: `out_valid` is high in exactly the cycle four clocks after a cycle with `in_valid` high, and `out_data` belongs to that byte.
- R5: Bytes presented on consecutive cycles are all accepted and come out on consecutive cycles.
- R6: The direction of each byte is set by the `in_mode` value sampled with it. Changing mode on every cycle gives each byte its own direction's result.
- R7: A clock edge with `rst` high discards every byte in flight. This includes a byte presented in that same cycle. `out_valid` is low in the cycle after that edge.
- R8: Running a forward result back through the unit in inverse mode returns the original byte.
- R9: A cycle with `in_valid` low produces no `out_valid`, whatever `in_data` and `in_mode` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the stage valid flags |
| in_valid | input | 1 | A byte is presented this cycle |
| in_mode | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_data | input | 8 | Byte to substitute |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | 8 | Substituted byte |

## Verification
The event that can coincide with normal flow is a reset edge arriving while bytes fill every stage and a new valid byte is presented in the same cycle. The bench runs a mixed-mode stream into the pipe and raises reset for one cycle with `in_valid` still high. Its model then drops every pending expectation. It checks on each following clock that `out_valid` stays low until bytes presented after the reset reach the end of the pipe. A second overlap is direction changes on every cycle while the pipe is full. These are judged against the bench's own table for each byte's own mode.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int DIB_W  = NIB_W / 2;
    localparam int MAP_W  = BYTE_W * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [DIB_W-1:0]  dib_t;

    // constant lambda of the top-level extension, {hi,lo} = {x+1, 0}
    localparam nib_t LAMBDA   = 4'b1100;
    localparam byte_t FWD_ADD = 8'h63;
    localparam byte_t INV_ADD = 8'h05;

    // ---------------- GF(2^2), basis {x,1}, x^2 = x + 1 ----------------
    function automatic dib_t g2_mul(dib_t a, dib_t b);
        return {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
                (a[1] & b[1]) ^ (a[0] & b[0])};
    endfunction

    function automatic dib_t g2_sq(dib_t a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    // multiply by phi = x
    function automatic dib_t g2_mulphi(dib_t a);
        return {a[1] ^ a[0], a[1]};
    endfunction

    // ---------------- GF(2^4), y^2 = y + phi ----------------
    function automatic nib_t g4_mul(nib_t a, nib_t b);
        dib_t hh, ll, mm;
        hh = g2_mul(a[3:2], b[3:2]);
        ll = g2_mul(a[1:0], b[1:0]);
        mm = g2_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]);
        return {mm ^ ll, g2_mulphi(hh) ^ ll};
    endfunction

    function automatic nib_t g4_sq(nib_t a);
        dib_t hs;
        hs = g2_sq(a[3:2]);
        return {hs, g2_mulphi(hs) ^ g2_sq(a[1:0])};
    endfunction

    function automatic nib_t g4_inv(nib_t a);
        dib_t nrm, ni;
        nrm = g2_mulphi(g2_sq(a[3:2])) ^ g2_mul(a[3:2], a[1:0]) ^ g2_sq(a[1:0]);
        ni  = g2_sq(nrm);   // in GF(4) the inverse is the square
        return {g2_mul(a[3:2], ni), g2_mul(a[3:2] ^ a[1:0], ni)};
    endfunction

    function automatic nib_t g4_mullam(nib_t a);
        return g4_mul(a, LAMBDA);
    endfunction

    // ---------------- GF(2^8), z^2 = z + lambda ----------------
    function automatic byte_t g8_mul(byte_t a, byte_t b);
        nib_t hh, ll, mm;
        hh = g4_mul(a[7:4], b[7:4]);
        ll = g4_mul(a[3:0], b[3:0]);
        mm = g4_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]);
        return {mm ^ ll, g4_mullam(hh) ^ ll};
    endfunction

    // norm of (h z + l) down to GF(2^4)
    function automatic nib_t g8_norm(byte_t a);
        return g4_mullam(g4_sq(a[7:4])) ^ g4_mul(a[7:4], a[3:0]) ^ g4_sq(a[3:0]);
    endfunction

    function automatic byte_t g8_pow(byte_t v, int n);
        byte_t r;
        r = 8'h01;
        for (int i = 0; i < n; i++) r = g8_mul(r, v);
        return r;
    endfunction

    // ---------------- linear maps ----------------
    function automatic byte_t map_apply(logic [MAP_W-1:0] m, byte_t x);
        byte_t r;
        r = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (x[i]) r ^= m[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    // column i = beta^i, beta a root of the AES polynomial in the tower
    function automatic logic [MAP_W-1:0] build_iso_fwd();
        logic [MAP_W-1:0] m;
        byte_t root, cand, pv, acc;
        logic  found;
        root  = 8'h02;
        found = 1'b0;
        m     = '0;
        for (int c = 2; c < 256; c++) begin
            cand = byte_t'(c);
            pv = g8_pow(cand, 8) ^ g8_pow(cand, 4) ^ g8_pow(cand, 3) ^ cand ^ 8'h01;
            if (!found && pv == 8'h00) begin
                root  = cand;
                found = 1'b1;
            end
        end
        acc = 8'h01;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i*BYTE_W +: BYTE_W] = acc;
            acc = g8_mul(acc, root);
        end
        return m;
    endfunction

    function automatic logic [MAP_W-1:0] build_iso_inv(logic [MAP_W-1:0] f);
        logic [MAP_W-1:0] m;
        m = '0;
        for (int j = 0; j < BYTE_W; j++)
            for (int v = 0; v < 256; v++)
                if (map_apply(f, byte_t'(v)) == byte_t'(1 << j))
                    m[j*BYTE_W +: BYTE_W] = byte_t'(v);
        return m;
    endfunction

    localparam logic [MAP_W-1:0] ISO_FWD = build_iso_fwd();
    localparam logic [MAP_W-1:0] ISO_INV = build_iso_inv(ISO_FWD);

    function automatic byte_t rotl(byte_t x, int k);
        return byte_t'((x << k) | (x >> (BYTE_W - k)));
    endfunction

    function automatic byte_t affine_fwd(byte_t x);
        return x ^ rotl(x, 1) ^ rotl(x, 2) ^ rotl(x, 3) ^ rotl(x, 4) ^ FWD_ADD;
    endfunction

    function automatic byte_t affine_inv(byte_t x);
        return rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ INV_ADD;
    endfunction

endpackage

// File: rtl/cfs_stage_reg.sv
module cfs_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_pay,
    output logic         out_vld,
    output logic [W-1:0] out_pay
);

    // only the valid flag is reset; payload is captured with its valid
    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= in_vld;
    end

    always_ff @(posedge clk) begin
        if (in_vld) out_pay <= in_pay;
    end

endmodule

// File: rtl/cfs_entry_map.sv
module cfs_entry_map
    import cfs_pkg::*;
(
    input  logic  mode,
    input  byte_t din,
    output byte_t dout
);

    byte_t pre;

    // inverse direction removes the affine step before entering the tower
    always_comb begin
        pre  = mode ? affine_inv(din) : din;
        dout = map_apply(ISO_FWD, pre);
    end

endmodule

// File: rtl/cfs_exit_map.sv
module cfs_exit_map
    import cfs_pkg::*;
(
    input  logic  mode,
    input  byte_t din,
    output byte_t dout
);

    byte_t lin;

    // forward direction applies the affine step after leaving the tower
    always_comb begin
        lin  = map_apply(ISO_INV, din);
        dout = mode ? lin : affine_fwd(lin);
    end

endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox
    import cfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    localparam int S1_W  = 1 + BYTE_W;
    localparam int S23_W = 1 + 3 * NIB_W;

    // stage 1: entry mapping
    byte_t            tw_in;
    logic             s1_vld;
    logic [S1_W-1:0]  s1_pay;

    cfs_entry_map u_entry (
        .mode (in_mode),
        .din  (in_data),
        .dout (tw_in)
    );

    cfs_stage_reg #(.W(S1_W)) u_s1 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_pay  ({in_mode, tw_in}),
        .out_vld (s1_vld),
        .out_pay (s1_pay)
    );

    // stage 2: norm of the tower element
    logic             s1_mode;
    byte_t            s1_tw;
    nib_t             s1_norm;
    logic             s2_vld;
    logic [S23_W-1:0] s2_pay;

    always_comb begin
        s1_mode = s1_pay[S1_W-1];
        s1_tw   = s1_pay[BYTE_W-1:0];
        s1_norm = g8_norm(s1_tw);
    end

    cfs_stage_reg #(.W(S23_W)) u_s2 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (s1_vld),
        .in_pay  ({s1_mode, s1_tw[7:4], s1_tw[7:4] ^ s1_tw[3:0], s1_norm}),
        .out_vld (s2_vld),
        .out_pay (s2_pay)
    );

    // stage 3: invert the norm in GF(2^4)
    logic             s2_mode;
    nib_t             s2_hi, s2_sum, s2_norm, s2_ninv;
    logic             s3_vld;
    logic [S23_W-1:0] s3_pay;

    always_comb begin
        s2_mode = s2_pay[S23_W-1];
        s2_hi   = s2_pay[3*NIB_W-1:2*NIB_W];
        s2_sum  = s2_pay[2*NIB_W-1:NIB_W];
        s2_norm = s2_pay[NIB_W-1:0];
        s2_ninv = g4_inv(s2_norm);
    end

    cfs_stage_reg #(.W(S23_W)) u_s3 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (s2_vld),
        .in_pay  ({s2_mode, s2_hi, s2_sum, s2_ninv}),
        .out_vld (s3_vld),
        .out_pay (s3_pay)
    );

    // stage 4: recombine, exit mapping, result register
    logic  s3_mode;
    nib_t  s3_hi, s3_sum, s3_ninv;
    byte_t tw_out, result;

    always_comb begin
        s3_mode = s3_pay[S23_W-1];
        s3_hi   = s3_pay[3*NIB_W-1:2*NIB_W];
        s3_sum  = s3_pay[2*NIB_W-1:NIB_W];
        s3_ninv = s3_pay[NIB_W-1:0];
        tw_out  = {g4_mul(s3_hi, s3_ninv), g4_mul(s3_sum, s3_ninv)};
    end

    cfs_exit_map u_exit (
        .mode (s3_mode),
        .din  (tw_out),
        .dout (result)
    );

    cfs_stage_reg #(.W(BYTE_W)) u_s4 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (s3_vld),
        .in_pay  (result),
        .out_vld (out_valid),
        .out_pay (out_data)
    );

endmodule

// File: rtl/aes_cf_sbox_chk.sv
module aes_cf_sbox_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_mode,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic [7:0] out_data
);

    // clean edges since the last reset edge, saturating
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R4, R9: output valid mirrors input valid four clocks earlier
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R7: nothing emerges right after a reset edge
    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R3: zero maps through the forward direction to 0x63
    p_zero_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 3'd4) && $past(in_valid, 4) && !$past(in_mode, 4)
          && ($past(in_data, 4) == 8'h00)) |-> (out_data == 8'h63));

    // R3: 0x63 maps through the inverse direction to zero
    p_zero_inv_r3: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 3'd4) && $past(in_valid, 4) && $past(in_mode, 4)
          && ($past(in_data, 4) == 8'h63)) |-> (out_data == 8'h00));

endmodule

bind aes_cf_sbox aes_cf_sbox_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_aes_cf_sbox.sv
module tb_aes_cf_sbox;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_mode = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;

    always #5 clk = ~clk;

    aes_cf_sbox dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] ref_fwd [256];
    logic [7:0] ref_inv [256];
    logic [7:0] fw_act  [256];

    int         due_q [$];
    logic [7:0] exp_q [$];
    logic [7:0] src_q [$];
    logic       mode_q[$];
    string      tag_q [$];
    string      idle_tag = "R9";

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    task automatic build_ref();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] iv = 8'h00;
            logic [7:0] s;
            for (int b = 1; b < 256; b++)
                if (ref_mul(8'(a), 8'(b)) == 8'h01) iv = 8'(b);
            for (int i = 0; i < 8; i++)
                s[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8]
                       ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            ref_fwd[a] = s;
        end
        for (int a = 0; a < 256; a++) ref_inv[ref_fwd[a]] = 8'(a);
    endtask

    task automatic compare();
        checks++;
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            if (!(out_valid === 1'b1 && out_data === exp_q[0])) begin
                fails++;
                $display("FAIL %s: src=%02h actual valid=%0b data=%02h expected valid=1 data=%02h",
                         tag_q[0], src_q[0], out_valid, out_data, exp_q[0]);
            end
            if (!mode_q[0]) fw_act[src_q[0]] = out_data;
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
            void'(src_q.pop_front());
            void'(mode_q.pop_front());
            void'(tag_q.pop_front());
        end else if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: actual valid=%0b data=%02h expected valid=0",
                     idle_tag, out_valid, out_data);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic m,
                        input logic [7:0] d, input logic [7:0] ex, input string tag);
        @(negedge clk);
        compare();
        rst      = r;
        in_valid = v;
        in_mode  = m;
        in_data  = d;
        if (r) begin
            due_q.delete(); exp_q.delete(); src_q.delete();
            mode_q.delete(); tag_q.delete();
        end else if (v) begin
            due_q.push_back(cyc + 4);
            exp_q.push_back(ex);
            src_q.push_back(d);
            mode_q.push_back(m);
            tag_q.push_back(tag);
        end
    endtask

    function automatic logic [7:0] expect_of(logic m, logic [7:0] d);
        return m ? ref_inv[d] : ref_fwd[d];
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'(i * 37), 8'h00, "R9");
    endtask

    initial begin
        logic [15:0] lf = 16'hace1;
        build_ref();

        // reset state, with valid bytes offered during reset (R7)
        idle_tag = "R7";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 8'(i), 8'h00, "R7");
        idle(6);

        // forward sweep back-to-back (R1, R3, R5)
        idle_tag = "R5";
        for (int i = 0; i < 256; i++)
            step(1'b0, 1'b1, 1'b0, 8'(i), ref_fwd[i], (i == 0) ? "R3" : "R1");
        idle(6);

        // round trip of the captured forward results (R8)
        idle_tag = "R8";
        for (int i = 0; i < 256; i++)
            step(1'b0, 1'b1, 1'b1, fw_act[i], 8'(i), "R8");
        idle(6);

        // inverse sweep (R2, R3)
        idle_tag = "R4";
        for (int i = 0; i < 256; i++)
            step(1'b0, 1'b1, 1'b1, 8'(255 - i), ref_inv[255 - i],
                 (i == 255 - 8'h63) ? "R3" : "R2");
        idle(6);

        // mode flips every cycle, back-to-back (R6)
        idle_tag = "R6";
        for (int i = 0; i < 256; i++) begin
            logic m = i[0];
            step(1'b0, 1'b1, m, 8'(i * 7 + 3), expect_of(m, 8'(i * 7 + 3)), "R6");
        end
        idle(6);

        // gapped stream, data and mode wiggle while invalid (R9, R4)
        idle_tag = "R9";
        for (int i = 0; i < 400; i++) begin
            logic v, m;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v  = lf[0] & lf[3];
            m  = lf[5];
            step(1'b0, v, m, lf[15:8], expect_of(m, lf[15:8]), "R4");
        end
        idle(6);

        // reset while the pipe is full and a byte is offered (R7)
        idle_tag = "R7";
        for (int i = 0; i < 3; i++) begin
            logic m = i[0];
            step(1'b0, 1'b1, m, 8'(i + 90), expect_of(m, 8'(i + 90)), "R7");
        end
        step(1'b1, 1'b1, 1'b1, 8'h63, 8'h00, "R7");
        for (int i = 0; i < 5; i++) begin
            logic m = ~i[0];
            step(1'b0, 1'b1, m, 8'(i + 200), expect_of(m, 8'(i + 200)), "R7");
        end
        idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule